// File: doc/BRIEF.md
# Port Pin-Change Interrupt Detector

This block watches the most significant pins of a general-purpose I/O port. It raises a single change flag when any of those pins, configured as an input, no longer matches a reference copy of its level. The reference copy is taken whenever software accesses the port, so the flag means "something moved since the port was last looked at". The block is designed for key-press wake-up, where the port exists mainly to signal that change.

The block receives pin levels that are already synchronized, the per-pin direction bits, one-cycle strobes for port reads and port writes, a software clear for the flag, and an interrupt-enable bit. It drives the change flag and a wake request for the power controller. While the mismatch remains, the flag cannot be cleared. Software first accesses the port, which retakes the reference, and then clears the flag.

An asynchronous active-low reset is released into the block through a short synchronizer. All state therefore leaves reset on a clock edge.

Top module: `port_change_detect`

## Requirements
- R1: While reset is applied, and on the first cycle after it is released, `chg_flag_o` and `wake_o` are 0. On the first active clock edge the reference copy loads from the pins, so steady pins never raise the flag.
- R2: Only pins `[PORT_W-1 : PORT_W-WATCH_W]` (bits 7:4 by default) take part. Changes on the lower pins never set the flag.
- R3: A watched pin whose direction bit is 0 (output) is excluded from the comparison. A direction bit of 1 marks an input that takes part.
- R4: A difference between any participating pin and its reference bit, in a cycle without a port access, sets the flag on the next clock edge. The per-pin differences are ORed together.
- R5: While such a difference persists, the flag is set again every cycle. A software clear in the same cycle loses to the set.
- R6: A port read (`port_rd_i`) or port write (`port_wr_i`) strobe reloads the reference from the current pins in that cycle, and that cycle sets nothing.
- R7: With no difference present, `flag_clr_i` clears the flag on the next edge. Without a clear, the flag holds, even after the pins return to their reference levels.
- R8: `wake_o` is high exactly when the flag is high and `int_en_i` is high, with no added delay.
- R9: Internal state leaves reset only on the `SYNC_STAGES`-th rising clock edge after `rst_n` goes high. Asserting `rst_n` low clears the flag at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PORT_W | Synchronized pin levels |
| dir_in_i | input | PORT_W | Direction bits, 1 = input, 0 = output |
| port_rd_i | input | 1 | One-cycle strobe for a port read |
| port_wr_i | input | 1 | One-cycle strobe for a port write |
| flag_clr_i | input | 1 | Software clear of the change flag |
| int_en_i | input | 1 | Change-interrupt enable, gates the wake request |
| chg_flag_o | output | 1 | Change interrupt flag |
| wake_o | output | 1 | Wake request |

## Verification
The bench builds the block with PORT_W = 8, WATCH_W = 4 and SYNC_STAGES = 2. These values give four non-watched pins, so the exclusion of the low pins can be exercised. The short synchronizer keeps the release timing inside a few cycles, where a stimulus change between edges shows whether the reference loaded one cycle early or late. With four watched pins, each pin can trigger the flag on its own, and direction bits can mask some watched pins while others stay live.

// File: rtl/port_change_pkg.sv
package port_change_pkg;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_act_e;

  function automatic flag_act_e pick_flag_act(input logic live_mm, input logic clr);
    if (live_mm)  return FLAG_SET;
    else if (clr) return FLAG_CLEAR;
    else          return FLAG_HOLD;
  endfunction

endpackage

// File: rtl/port_change_rst_sync.sv
module port_change_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/port_change_snapshot.sv
module port_change_snapshot #(
  parameter int WATCH_W = 4
) (
  input  logic               clk,
  input  logic               rst_int_n,
  input  logic [WATCH_W-1:0] pins_hi,
  input  logic               access,
  output logic [WATCH_W-1:0] snap,
  output logic               snap_valid
);
  logic               load_en;
  logic [WATCH_W-1:0] snap_d;
  logic               valid_d;

  always_comb begin
    load_en = !snap_valid || access;
    snap_d  = pins_hi;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      snap       <= '0;
      snap_valid <= 1'b0;
    end else if (load_en) begin
      snap       <= snap_d;
      snap_valid <= valid_d;
    end
  end
endmodule

// File: rtl/port_change_compare.sv
module port_change_compare #(
  parameter int WATCH_W = 4
) (
  input  logic [WATCH_W-1:0] pins_hi,
  input  logic [WATCH_W-1:0] dir_hi,
  input  logic [WATCH_W-1:0] snap,
  input  logic               snap_valid,
  input  logic               access,
  output logic [WATCH_W-1:0] pin_diff,
  output logic               live_mm
);
  genvar gi;
  generate
    for (gi = 0; gi < WATCH_W; gi++) begin : g_pin
      assign pin_diff[gi] = dir_hi[gi] && (pins_hi[gi] != snap[gi]);
    end
  endgenerate

  assign live_mm = snap_valid && !access && (|pin_diff);
endmodule

// File: rtl/port_change_flag.sv
module port_change_flag
  import port_change_pkg::*;
(
  input  logic clk,
  input  logic rst_int_n,
  input  logic live_mm,
  input  logic clr,
  output logic flag_q
);
  flag_act_e act;
  logic      flag_en;
  logic      flag_d;

  always_comb begin
    act     = pick_flag_act(live_mm, clr);
    flag_en = (act != FLAG_HOLD);
    flag_d  = (act == FLAG_SET);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/port_change_detect.sv
module port_change_detect #(
  parameter int PORT_W      = 8,
  parameter int WATCH_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] dir_in_i,
  input  logic              port_rd_i,
  input  logic              port_wr_i,
  input  logic              flag_clr_i,
  input  logic              int_en_i,
  output logic              chg_flag_o,
  output logic              wake_o
);
  localparam int LO_W = PORT_W - WATCH_W;

  logic               rst_int_n;
  logic [WATCH_W-1:0] pins_hi;
  logic [WATCH_W-1:0] dir_hi;
  logic [WATCH_W-1:0] snap;
  logic [WATCH_W-1:0] pin_diff;
  logic               snap_valid;
  logic               access;
  logic               live_mm;

  assign pins_hi = pin_i[PORT_W-1:LO_W];
  assign dir_hi  = dir_in_i[PORT_W-1:LO_W];
  assign access  = port_rd_i || port_wr_i;

  generate
    if (LO_W > 0) begin : g_lo
      logic unused_lo;
      assign unused_lo = ^{pin_i[LO_W-1:0], dir_in_i[LO_W-1:0], pin_diff};
    end else begin : g_nolo
      logic unused_diff;
      assign unused_diff = ^pin_diff;
    end
  endgenerate

  port_change_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  port_change_snapshot #(.WATCH_W(WATCH_W)) u_snap (
    .clk        (clk),
    .rst_int_n  (rst_int_n),
    .pins_hi    (pins_hi),
    .access     (access),
    .snap       (snap),
    .snap_valid (snap_valid)
  );

  port_change_compare #(.WATCH_W(WATCH_W)) u_cmp (
    .pins_hi    (pins_hi),
    .dir_hi     (dir_hi),
    .snap       (snap),
    .snap_valid (snap_valid),
    .access     (access),
    .pin_diff   (pin_diff),
    .live_mm    (live_mm)
  );

  port_change_flag u_flag (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .live_mm   (live_mm),
    .clr       (flag_clr_i),
    .flag_q    (chg_flag_o)
  );

  assign wake_o = chg_flag_o && int_en_i;
endmodule

// File: rtl/port_change_checker.sv
module port_change_checker (
  input logic clk,
  input logic rst_int_n,
  input logic flag,
  input logic wake,
  input logic clr,
  input logic rd,
  input logic wr,
  input logic live_mm
);
  p_reset_r1: assert property (@(posedge clk) !rst_int_n |-> !flag);

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    live_mm |=> flag);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (live_mm && clr) |=> flag);

  p_access_quiet_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flag && (rd || wr)) |=> !flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr && !live_mm) |=> !flag);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag && !clr) |=> flag);

  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    wake |-> flag);
endmodule

bind port_change_detect port_change_checker u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .flag      (chg_flag_o),
  .wake      (wake_o),
  .clr       (flag_clr_i),
  .rd        (port_rd_i),
  .wr        (port_wr_i),
  .live_mm   (live_mm)
);

// File: tb/tb_port_change_detect.sv
module tb_port_change_detect;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int WW = 4;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] pin = '0;
  logic [PW-1:0] dir = '1;
  logic          rd = 1'b0, wr = 1'b0, clr = 1'b0, ie = 1'b0;
  logic          flag, wake;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  port_change_detect #(.PORT_W(PW), .WATCH_W(WW), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_in_i(dir),
    .port_rd_i(rd), .port_wr_i(wr), .flag_clr_i(clr), .int_en_i(ie),
    .chg_flag_o(flag), .wake_o(wake)
  );

  // behavioural reference model
  int m_cnt;
  bit m_valid;
  bit m_flag;
  bit m_snap [WW];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   = 0;
      m_valid = 0;
      m_flag  = 0;
    end else if (m_cnt < SS) begin
      m_cnt = m_cnt + 1;
    end else begin
      bit acc;
      bit mm;
      acc = rd || wr;
      mm  = 0;
      if (m_valid && !acc)
        for (int i = 0; i < WW; i++)
          if (dir[PW-WW+i] && (pin[PW-WW+i] != m_snap[i])) mm = 1;
      if (!m_valid || acc) begin
        for (int i = 0; i < WW; i++) m_snap[i] = pin[PW-WW+i];
        m_valid = 1;
      end
      if (mm)       m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  task automatic compare();
    bit exp_wake;
    exp_wake = m_flag && ie;
    checks++;
    if (flag !== m_flag) begin
      errors++;
      $display("FAIL %s flag act=%0b exp=%0b t=%0t", phase, flag, m_flag, $time);
    end
    checks++;
    if (wake !== exp_wake) begin
      errors++;
      $display("FAIL R8/%s wake act=%0b exp=%0b t=%0t", phase, wake, exp_wake, $time);
    end
  endtask

  // drive after a negedge, then move to the next negedge and compare
  task automatic cyc(input logic [PW-1:0] p, input logic [PW-1:0] d,
                     input logic r, input logic w, input logic c, input logic e);
    pin = p; dir = d; rd = r; wr = w; clr = c; ie = e;
    @(negedge clk);
    compare();
  endtask

  task automatic expect_flag(input bit exp, input string tag);
    checks++;
    if (flag !== exp) begin
      errors++;
      $display("FAIL %s directed flag act=%0b exp=%0b", tag, flag, exp);
    end
  endtask

  bit done = 0;
  initial begin
    int n;
    n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 20000) begin
        errors++;
        $display("FAIL watchdog expired act=%0d exp<=20000 cycles", n);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    phase = "R1";
    cyc(8'hA5, 8'hFF, 0, 0, 0, 1);
    cyc(8'h5A, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R1");
    rst_n = 1'b1;
    // R9: release timing, pins move between edges
    phase = "R9";
    cyc(8'h30, 8'hFF, 0, 0, 0, 1);
    cyc(8'h50, 8'hFF, 0, 0, 0, 1);
    cyc(8'h50, 8'hFF, 0, 0, 0, 1);
    cyc(8'h50, 8'hFF, 0, 0, 0, 1);
    phase = "R1";
    expect_flag(0, "R1");
    // R2: low pins ignored
    phase = "R2";
    for (int k = 0; k < 16; k++) cyc({4'h5, k[3:0]}, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R2");
    // R3: outputs excluded, then flipped to input
    phase = "R3";
    cyc(8'hA0, 8'h0F, 0, 0, 0, 1);
    cyc(8'hF0, 8'h0F, 0, 0, 0, 1);
    expect_flag(0, "R3");
    cyc(8'hF0, 8'h8F, 0, 0, 0, 1);
    cyc(8'hF0, 8'h8F, 0, 0, 0, 1);
    expect_flag(1, "R3");
    phase = "R6";
    cyc(8'hF0, 8'hFF, 1, 0, 0, 1);
    cyc(8'hF0, 8'hFF, 0, 0, 1, 1);
    cyc(8'hF0, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R6");
    // R4: each watched pin alone
    phase = "R4";
    for (int i = 4; i < 8; i++) begin
      logic [PW-1:0] p;
      p = 8'hF0 ^ (8'h01 << i);
      cyc(p, 8'hFF, 0, 0, 0, 0);
      cyc(p, 8'hFF, 0, 0, 0, 0);
      expect_flag(1, "R4");
      cyc(8'hF0, 8'hFF, 0, 1, 0, 1);
      cyc(8'hF0, 8'hFF, 0, 0, 1, 1);
      cyc(8'hF0, 8'hFF, 0, 0, 0, 1);
    end
    // R5: clear loses while mismatch persists
    phase = "R5";
    cyc(8'h70, 8'hFF, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) cyc(8'h70, 8'hFF, 0, 0, 1, 1);
    expect_flag(1, "R5");
    // R6: read with clear in the same cycle clears
    phase = "R6";
    cyc(8'h70, 8'hFF, 1, 0, 1, 1);
    cyc(8'h70, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R6");
    // R6: access cycle with a fresh difference sets nothing
    cyc(8'h20, 8'hFF, 0, 1, 0, 1);
    cyc(8'h20, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R6");
    // R7: flag holds after pins return, clear then works
    phase = "R7";
    cyc(8'hA0, 8'hFF, 0, 0, 0, 1);
    cyc(8'h20, 8'hFF, 0, 0, 0, 1);
    cyc(8'h20, 8'hFF, 0, 0, 0, 1);
    expect_flag(1, "R7");
    cyc(8'h20, 8'hFF, 0, 0, 1, 1);
    cyc(8'h20, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R7");
    // R8: wake gated by enable
    phase = "R8";
    cyc(8'h60, 8'hFF, 0, 0, 0, 0);
    cyc(8'h60, 8'hFF, 0, 0, 0, 0);
    cyc(8'h60, 8'hFF, 0, 0, 0, 1);
    cyc(8'h60, 8'hFF, 0, 0, 0, 0);
    // R9: async reset with flag set
    phase = "R9";
    rst_n = 1'b0;
    #1;
    expect_flag(0, "R9");
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    cyc(8'h10, 8'hFF, 0, 0, 0, 1);
    cyc(8'h90, 8'hFF, 0, 0, 0, 1);
    cyc(8'h90, 8'hFF, 0, 0, 0, 1);
    cyc(8'h90, 8'hFF, 0, 0, 0, 1);
    expect_flag(0, "R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule